// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block runs one command at a time on a byte-wide serial EEPROM that has a chip select, a serial clock and a single data line. The data line is driven by the engine for commands and write data, and by the device for read data and for its ready flag. The host drives one command strobe carrying a command code, a 7-bit address and, for the two write commands, a data byte. The engine then builds the serial frame, clocks it out most significant bit first and captures read data. After any programming command it waits for the device to report that it is ready. It reports this with busy, done and timeout outputs.

Each frame has a fixed length. Commands without data use ten serial clocks: a start bit, two opcode bits and seven address bits. Commands that carry a data byte use eighteen serial clocks. The serial clock runs at the system clock divided by `2*CLK_DIV`. The ready-wait window is `TIMEOUT_CYC` system clocks, which is 30 ms at the default setting for a 250 MHz clock.

Top module: `mw_eeprom_engine`

## Requirements
- R1: ERASE (code 2), ENABLE (code 3), DISABLE (code 4) and ERASE_ALL (code 5) frames give exactly 10 rising serial clock edges while chip select is high.
- R2: READ (code 0), WRITE (code 1) and WRITE_ALL (code 6) frames give exactly 18 rising serial clock edges while chip select is high.
- R3: Every frame starts with a 1, followed by the opcode and then seven address bits, all most significant bit first. The opcodes are READ=10, WRITE=01 and ERASE=11, each with the host address. The four remaining commands use opcode 00 with the top two address bits as a sub-code (ENABLE=11, ERASE_ALL=10, WRITE_ALL=01, DISABLE=00) and zero in the low five bits.
- R4: WRITE and WRITE_ALL send the host data byte after the address, D7 first. READ shifts in eight bits, D7 first, and rd_data holds the byte once done rises.
- R5: The data-line output enable is low during the eight read data bits and during the ready wait.
- R6: After WRITE, ERASE, ERASE_ALL or WRITE_ALL, chip select stays low for at least one serial clock period and then goes high. The engine samples the data line until it reads 1, then drops chip select and sets done.
- R7: If the device is not ready within TIMEOUT_CYC system clocks after the end of the frame, timeout is set, done stays low, busy falls and chip select drops.
- R8: busy rises in the cycle after a command is accepted and stays high until done or timeout. A strobe while busy is ignored and causes no extra frame.
- R9: Code 7 is ignored. busy stays low and no frame is sent.
- R10: Accepting a new command clears done and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code (0..6, 7 ignored) |
| cmd_addr | input | 7 | Byte address |
| cmd_wdata | input | 8 | Write data byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command completed |
| timeout | output | 1 | Last command timed out waiting for ready |
| rd_data | output | 8 | Byte from the last READ |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sck | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Serial data toward the EEPROM |
| ee_oe | output | 1 | Output enable for ee_do on the shared data line |
| ee_di | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach from the ports is the timeout. A well-behaved device always reports ready, so the bench's device model has a stuck mode that keeps the data line low through the whole ready wait. The bench then measures the time from the end of the frame to the fall of busy. The rejected-strobe case is reached by firing a second WRITE in the cycle after the first is accepted. The bench then counts the frames the device model decoded and reads back the address the second WRITE would have changed.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_READ      = 3'd0,
    CMD_WRITE     = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_ENABLE    = 3'd3,
    CMD_DISABLE   = 3'd4,
    CMD_ERASE_ALL = 3'd5,
    CMD_WRITE_ALL = 3'd6,
    CMD_NONE      = 3'd7
  } mw_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_POLL  = 2'd3
  } mw_state_e;

  localparam int HDR_BITS   = 10;
  localparam int FRAME_BITS = 18;

  // serial clock count for a command
  function automatic logic [4:0] mw_len(mw_cmd_e c);
    case (c)
      CMD_READ, CMD_WRITE, CMD_WRITE_ALL: return 5'(FRAME_BITS);
      default:                            return 5'(HDR_BITS);
    endcase
  endfunction

  // frame bits, left aligned, start bit in bit 17
  function automatic logic [17:0] mw_frame(mw_cmd_e c, logic [6:0] a, logic [7:0] d);
    logic [1:0] op;
    logic [6:0] ad;
    logic [7:0] dt;
    op = 2'b00;
    ad = a;
    dt = 8'h00;
    case (c)
      CMD_READ:      op = 2'b10;
      CMD_WRITE:     begin op = 2'b01; dt = d; end
      CMD_ERASE:     op = 2'b11;
      CMD_ENABLE:    ad = 7'b11_00000;
      CMD_ERASE_ALL: ad = 7'b10_00000;
      CMD_WRITE_ALL: begin ad = 7'b01_00000; dt = d; end
      default:       ad = 7'b00_00000;
    endcase
    return {1'b1, op, ad, dt};
  endfunction

  // command needs a ready wait after its frame
  function automatic logic mw_programs(mw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) ||
           (c == CMD_ERASE_ALL) || (c == CMD_WRITE_ALL);
  endfunction

  // bit index belongs to the captured read data
  function automatic logic mw_captures(mw_cmd_e c, logic [4:0] idx);
    return (c == CMD_READ) && (idx >= 5'(HDR_BITS));
  endfunction

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  a_r1_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int LIMIT = 7_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  a_r7_expire_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> run);
endmodule

// File: rtl/mw_eeprom_engine.sv
module mw_eeprom_engine
  import mw_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int TIMEOUT_CYC = 7_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic [6:0] cmd_addr,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic       timeout,
  output logic [7:0] rd_data,
  output logic       ee_cs,
  output logic       ee_sck,
  output logic       ee_do,
  output logic       ee_oe,
  input  logic       ee_di
);

  mw_state_e   state;
  mw_cmd_e     cmd_q;
  logic [17:0] frame_q;
  logic [4:0]  len_q;
  logic [4:0]  bitn;
  logic        phase;
  logic        gap_half;
  logic [7:0]  rd_shift;
  logic [4:0]  rise_cnt;
  logic        done_q, timeout_q, cs_q, sck_q;

  // named internal events
  logic tick, expired;
  logic launch, sck_rise, sck_fall, frame_end, capture, poll_ok;

  mw_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .run((state == ST_SHIFT) || (state == ST_GAP)),
    .tick(tick)
  );

  mw_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run((state == ST_GAP) || (state == ST_POLL)),
    .expired(expired)
  );

  assign launch    = cmd_valid && (state == ST_IDLE) && (mw_cmd_e'(cmd_code) != CMD_NONE);
  assign sck_rise  = (state == ST_SHIFT) && tick && !phase;
  assign sck_fall  = (state == ST_SHIFT) && tick && phase;
  assign frame_end = sck_fall && (bitn == len_q - 5'd1);
  assign capture   = sck_rise && mw_captures(cmd_q, bitn);
  assign poll_ok   = (state == ST_POLL) && !expired && ee_di;

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign timeout = timeout_q;
  assign ee_cs   = cs_q;
  assign ee_sck  = sck_q;
  assign ee_do   = (state == ST_SHIFT) && frame_q[17];
  assign ee_oe   = (state == ST_SHIFT) && !mw_captures(cmd_q, bitn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd_q     <= CMD_NONE;
      frame_q   <= '0;
      len_q     <= '0;
      bitn      <= '0;
      phase     <= 1'b0;
      gap_half  <= 1'b0;
      rd_shift  <= '0;
      rd_data   <= '0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
      cs_q      <= 1'b0;
      sck_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          cmd_q     <= mw_cmd_e'(cmd_code);
          frame_q   <= mw_frame(mw_cmd_e'(cmd_code), cmd_addr, cmd_wdata);
          len_q     <= mw_len(mw_cmd_e'(cmd_code));
          bitn      <= '0;
          phase     <= 1'b0;
          sck_q     <= 1'b0;
          cs_q      <= 1'b1;
          done_q    <= 1'b0;
          timeout_q <= 1'b0;
          state     <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sck_rise) begin
            sck_q <= 1'b1;
            phase <= 1'b1;
            if (capture) rd_shift <= {rd_shift[6:0], ee_di};
          end else if (sck_fall) begin
            sck_q <= 1'b0;
            phase <= 1'b0;
            if (frame_end) begin
              cs_q <= 1'b0;
              if (mw_programs(cmd_q)) begin
                gap_half <= 1'b0;
                state    <= ST_GAP;
              end else begin
                if (cmd_q == CMD_READ) rd_data <= rd_shift;
                done_q <= 1'b1;
                state  <= ST_IDLE;
              end
            end else begin
              bitn    <= bitn + 5'd1;
              frame_q <= {frame_q[16:0], 1'b0};
            end
          end
        end
        ST_GAP: begin
          if (expired) begin
            timeout_q <= 1'b1;
            state     <= ST_IDLE;
          end else if (tick) begin
            if (gap_half) begin
              cs_q  <= 1'b1;
              state <= ST_POLL;
            end
            gap_half <= 1'b1;
          end
        end
        ST_POLL: begin
          if (expired) begin
            cs_q      <= 1'b0;
            timeout_q <= 1'b1;
            state     <= ST_IDLE;
          end else if (poll_ok) begin
            cs_q   <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // rising serial clocks seen in the current frame (checking only)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rise_cnt <= '0;
    else if (launch)   rise_cnt <= '0;
    else if (sck_rise) rise_cnt <= rise_cnt + 5'd1;
  end

  // R1, R2: frame length by command class
  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (rise_cnt == mw_len(cmd_q)));

  a_r1_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sck |-> ee_cs);

  a_r3_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && $past(state) == ST_IDLE) |-> (ee_do && ee_oe && ee_cs));

  a_r5_no_drive_in_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL) |-> !ee_oe);

  a_r6_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && $past(state) == ST_POLL) |-> $past(ee_di));

  a_r7_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (!busy && !ee_cs && !done));

  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(cmd_q));

  a_r9_no_code7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_code == 3'd7) |=> !busy);
endmodule

// File: tb/mw_eeprom_engine_test.sv
module mw_eeprom_engine_test;
  localparam int CLK_DIV  = 2;
  localparam int TMO      = 600;
  localparam int DEV_BUSY = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [6:0] cmd_addr = 7'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic       busy, done, timeout, ee_cs, ee_sck, ee_do, ee_oe, ee_di;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  mw_eeprom_engine #(.CLK_DIV(CLK_DIV), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .timeout(timeout), .rd_data(rd_data), .ee_cs(ee_cs), .ee_sck(ee_sck),
    .ee_do(ee_do), .ee_oe(ee_oe), .ee_di(ee_di)
  );

  // ---------------- device model ----------------
  logic [7:0]  mem [128];
  logic        wen = 1'b0, stuck = 1'b0;
  logic        sck_p = 1'b0, cs_p = 1'b0;
  logic [17:0] rx = '0, last_rx = '0;
  int          bitcnt = 0, last_cnt = 0, frames = 0;
  int          busy_left = 0, low_run = 0, last_gap = 0;
  int          cyc = 0, t_end = 0;
  logic        rd_mode = 1'b0, rd_bit = 1'b0, oe_bad = 1'b0;
  logic [6:0]  rd_adr = '0;

  assign ee_di = rd_mode ? rd_bit : ((busy_left == 0) && !stuck);

  always @(posedge clk) begin : dev
    logic [17:0] nb;
    logic [9:0]  hdr;
    int n;
    sck_p <= ee_sck;
    cs_p  <= ee_cs;
    cyc   <= cyc + 1;
    if (busy_left > 0) busy_left <= busy_left - 1;
    if (!ee_cs) low_run <= low_run + 1;
    if (ee_cs && !cs_p) begin
      last_gap <= low_run;
      oe_bad   <= 1'b0;
    end
    if (ee_cs && ee_sck && !sck_p) begin
      nb = {rx[16:0], ee_do};
      n  = bitcnt + 1;
      rx     <= nb;
      bitcnt <= n;
      if (rd_mode && ee_oe) oe_bad <= 1'b1;
      if (n == 10 && nb[8:7] == 2'b10) begin
        rd_mode <= 1'b1;
        rd_adr  <= nb[6:0];
        rd_bit  <= mem[nb[6:0]][7];
      end else if (rd_mode && n < 18) begin
        rd_bit <= mem[rd_adr][17 - n];
      end
    end
    if (!ee_cs && cs_p) begin
      low_run <= 1;
      if (bitcnt != 0) begin
        hdr = (bitcnt == 18) ? rx[17:8] : rx[9:0];
        frames   <= frames + 1;
        last_rx  <= rx;
        last_cnt <= bitcnt;
        t_end    <= cyc;
        bitcnt   <= 0;
        rd_mode  <= 1'b0;
        case (hdr[8:7])
          2'b01: if (wen && bitcnt == 18) begin mem[hdr[6:0]] <= rx[7:0]; busy_left <= DEV_BUSY; end
          2'b11: if (wen) begin mem[hdr[6:0]] <= 8'hFF; busy_left <= DEV_BUSY; end
          2'b00: case (hdr[6:5])
            2'b11: wen <= 1'b1;
            2'b00: wen <= 1'b0;
            2'b10: if (wen) begin
              for (int i = 0; i < 128; i++) mem[i] <= 8'hFF;
              busy_left <= DEV_BUSY;
            end
            default: if (wen && bitcnt == 18) begin
              for (int i = 0; i < 128; i++) mem[i] <= rx[7:0];
              busy_left <= DEV_BUSY;
            end
          endcase
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] c);
    return (c == 3'd0 || c == 3'd1 || c == 3'd6) ? 18 : 10;
  endfunction

  function automatic logic [9:0] exp_hdr(input logic [2:0] c, input logic [6:0] a);
    logic [1:0] sub;
    case (c)
      3'd0: return {3'b110, a};
      3'd1: return {3'b101, a};
      3'd2: return {3'b111, a};
      default: begin
        sub = (c == 3'd3) ? 2'b11 : (c == 3'd5) ? 2'b10 : (c == 3'd6) ? 2'b01 : 2'b00;
        return {3'b100, sub, 5'b0};
      end
    endcase
  endfunction

  task automatic issue(input logic [2:0] c, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] c, input logic [6:0] a, input logic [7:0] d,
                         input string req);
    int f0;
    f0 = frames;
    issue(c, a, d);
    check(busy === 1'b1, "R8", "busy after launch", busy, 1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(frames == f0 + 1, "R8", "one frame per command", frames - f0, 1);
    check(last_cnt == exp_len(c), req, "frame length", last_cnt, exp_len(c));
    if (exp_len(c) == 18)
      check(last_rx[17:8] == exp_hdr(c, a), "R3", "header bits", last_rx[17:8], exp_hdr(c, a));
    else
      check(last_rx[9:0] == exp_hdr(c, a), "R3", "header bits", last_rx[9:0], exp_hdr(c, a));
    if (c == 3'd1 || c == 3'd6)
      check(last_rx[7:0] == d, "R4", "write data bits", last_rx[7:0], d);
    if (!stuck) check(done === 1'b1 && timeout === 1'b0, "R10", "done status", {done, timeout}, 2'b10);
    if (c == 3'd1 || c == 3'd2 || c == 3'd5 || c == 3'd6)
      check(last_gap >= 2 * CLK_DIV, "R6", "cs low before ready wait", last_gap, 2 * CLK_DIV);
  endtask

  task automatic read_chk(input logic [6:0] a, input logic [7:0] exp);
    run_cmd(3'd0, a, 8'h00, "R2");
    check(rd_data == exp, "R4", "read data", rd_data, exp);
    check(oe_bad == 1'b0, "R5", "oe released in read data", oe_bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int f0, el;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h3C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, timeout, ee_cs, ee_sck, ee_oe} == 6'b0, "R8", "reset state",
          {busy, done, timeout, ee_cs, ee_sck, ee_oe}, 0);

    // write while device disabled: frame still sent, contents unchanged
    run_cmd(3'd1, 7'd20, 8'hAA, "R2");
    read_chk(7'd20, 8'd20 ^ 8'h3C);

    run_cmd(3'd3, 7'd0, 8'h00, "R1");     // ENABLE
    for (int a = 0; a < 128; a++) begin
      logic [7:0] v;
      v = 8'((a * 37 + 11) & 255);
      run_cmd(3'd1, 7'(a), v, "R2");
      read_chk(7'(a), v);
    end

    run_cmd(3'd2, 7'd9, 8'h00, "R1");     // ERASE
    read_chk(7'd9, 8'hFF);
    run_cmd(3'd6, 7'd0, 8'h5A, "R2");     // WRITE_ALL
    read_chk(7'd0, 8'h5A);
    read_chk(7'd64, 8'h5A);
    read_chk(7'd127, 8'h5A);
    run_cmd(3'd5, 7'd0, 8'h00, "R1");     // ERASE_ALL
    read_chk(7'd3, 8'hFF);
    run_cmd(3'd4, 7'd0, 8'h00, "R1");     // DISABLE
    run_cmd(3'd1, 7'd3, 8'h00, "R2");
    read_chk(7'd3, 8'hFF);
    run_cmd(3'd3, 7'd0, 8'h00, "R1");

    // R8: strobe during busy is ignored
    f0 = frames;
    issue(3'd1, 7'd6, 8'h11);
    cmd_valid = 1'b1; cmd_code = 3'd1; cmd_addr = 7'd7; cmd_wdata = 8'h22;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(frames == f0 + 1, "R8", "ignored strobe frames", frames - f0, 1);
    read_chk(7'd7, 8'hFF);
    read_chk(7'd6, 8'h11);

    // R9: code 7 ignored
    f0 = frames;
    issue(3'd7, 7'd1, 8'h00);
    check(busy === 1'b0 && ee_cs === 1'b0, "R9", "code 7 busy/cs", {busy, ee_cs}, 0);
    repeat (20) @(negedge clk);
    check(frames == f0, "R9", "code 7 frames", frames - f0, 0);

    // R7: timeout
    stuck = 1'b1;
    run_cmd(3'd1, 7'd8, 8'h33, "R2");
    el = cyc - t_end;
    check(timeout === 1'b1 && done === 1'b0, "R7", "timeout status", {timeout, done}, 2'b10);
    check(ee_cs === 1'b0, "R7", "cs after timeout", ee_cs, 0);
    check(el >= TMO - 4 && el <= TMO + 4, "R7", "timeout window", el, TMO);
    stuck = 1'b0;
    run_cmd(3'd3, 7'd0, 8'h00, "R1");
    check(timeout === 1'b0, "R10", "timeout cleared", timeout, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule